// File: doc/BRIEF.md
# Matrix Slave-Port Arbiter

This block decides which of several bus masters may drive one slave port of a multi-master bus matrix. Each master raises a request line and holds it for a burst of beats. It marks the final beat with a burst-end line, and it may raise a lock line to keep its burst from being cut. The arbiter returns a one-hot grant vector and a grant-valid flag. Grant-valid is high in any cycle where the granted master is actually requesting, which makes that cycle a transferred beat.

Arbitration is registered. A choice made in one cycle shows on the grant in the next cycle. The choice follows a rotating priority that starts just past the previous winner. While nobody requests, a selectable parking policy decides who holds the grant:

- nobody holds it;
- the last owner keeps it;
- a programmed master number holds it.

A parked master that starts requesting transfers at once, with no arbitration cycle. A programmable slot limit cuts bursts that run too long, so that waiting masters are served.

Top module: `matrix_slave_arbiter`

## Requirements
- R1: After a synchronous active-low reset, `grant_o` is all zero and `grant_valid_o` is low.
- R2: `grant_o` has at most one bit set. `grant_valid_o` is high in exactly those cycles where the granted master's `req_i` bit is high, in that same cycle. Grant-valid cannot be high with an empty grant.
- R3: Arbitration searches the requesting masters in rotating order. The search starts at the master numbered one above the previous arbitration winner, and it wraps from NUM_MASTERS-1 to 0. After reset the search starts at master 0. The winner's grant bit appears in the cycle after the decision.
- R4: A beat on which the owner's `last_i` bit is high ends the burst, and arbitration runs in that cycle. The owner's own request is ignored in that arbitration, so the next grant goes to another requester, or to the park policy if there is none.
- R5: Park mode code 0 (and the unused code 3) means no parking. With no request, the grant in the next cycle is all zero.
- R6: Park mode code 1 keeps the current owner's grant bit set while no request is pending.
- R7: Park mode code 2 parks on master `park_id_i` while no request is pending, including right after reset. If `park_id_i` is NUM_MASTERS or more, code 2 behaves like code 0.
- R8: A master that is parked on the slave and raises its request gets `grant_valid_o` high in that same cycle.
- R9: With a non-zero `slot_limit_i` = L, a burst that runs L beats without `last_i` is broken after its L-th beat. Arbitration then runs with the owner's request still counted, so the owner is regranted only if no other master requests.
- R10: `slot_limit_i` = 0 disables burst breaking. A burst then holds the grant until `last_i` or until its request drops.
- R11: While the owner holds its `lock_i` bit, the slot limit does not break its burst. On the first beat after lock drops with the limit already reached, the burst is broken.
- R12: When `last_i` and slot-limit expiry fall on the same beat, the burst-end rule of R4 applies: the owner's request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | NUM_MASTERS | Per-master request, held for the burst |
| lock_i | input | NUM_MASTERS | Per-master lock, shields the owner's burst from the slot limit |
| last_i | input | NUM_MASTERS | Per-master burst-end flag, valid on the final beat |
| park_mode_i | input | 2 | Parking policy: 0 none, 1 last owner, 2 fixed master, 3 none |
| park_id_i | input | ID_W | Master number used by fixed parking |
| slot_limit_i | input | SLOT_W | Maximum beats per burst, 0 disables breaking |
| grant_o | output | NUM_MASTERS | One-hot grant, zero when nobody owns the slave |
| grant_valid_o | output | 1 | Granted master is requesting in this cycle (a beat) |

## Verification
The slot limit and the burst-end flag can both expire on the same beat. The two rules treat the owner's request differently: a slot break counts it, while a burst end ignores it. To provoke the collision, one sole requester runs with a limit of two and raises its end flag on its second beat, then keeps requesting. The check is that the grant drops to empty in the next cycle, as the no-parking policy requires. A slot break alone would have regranted that same master. A lock that is released after the limit has passed is a second overlap of this kind, and it is checked by watching for the handover on the exact beat the lock falls.

// File: rtl/arb_pkg.sv
// Package: shared types for the matrix slave-port arbiter.
// Assumes: park mode code 3 is unused and treated like "no parking".
package arb_pkg;

    typedef enum logic [1:0] {
        PARK_NONE  = 2'd0,
        PARK_LAST  = 2'd1,
        PARK_FIXED = 2'd2,
        PARK_RSVD  = 2'd3
    } park_mode_e;

endpackage

// File: rtl/arb_rr_pick.sv
// Module: arb_rr_pick
// Rotating-priority picker. It returns the first set request found when
// searching upward from ptr, wrapping at N-1.
// Assumes: ptr is always below N.
module arb_rr_pick #(
    parameter int unsigned N    = 10,
    parameter int unsigned ID_W = $clog2(N)
) (
    input  logic [N-1:0]    req,
    input  logic [ID_W-1:0] ptr,
    output logic            any,
    output logic [ID_W-1:0] pick
);

    // Purpose: scan N positions starting at ptr and keep the first hit.
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int k = 0; k < int'(N); k++) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= int'(N)) idx = idx - int'(N);
            if (!any && req[idx]) begin
                any  = 1'b1;
                pick = ID_W'(idx);
            end
        end
    end

endmodule

// File: rtl/arb_slot_timer.sv
// Module: arb_slot_timer
// Counts the beats of the current burst and flags the beat on which the
// slot limit is reached. A held lock masks the flag. The count restarts
// on any beat-free cycle and on any burst end.
// Assumes: beat is high only while the granted master requests.
module arb_slot_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          beat,
    input  logic          end_last,
    input  logic          lock_in,
    input  logic [CW-1:0] limit,
    output logic          expire
);

    logic [CW-1:0] cnt_q;
    logic          reached;

    // Purpose: decide whether this beat is at or beyond the limit.
    always_comb begin
        reached = (limit != '0) && (cnt_q >= (limit - CW'(1)));
        expire  = beat && reached && !lock_in;
    end

    // Purpose: count beats, saturating, and restart on idle or burst end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!beat || expire || end_last) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // R9: a break restarts the count for the next owner's burst
    assert_slot_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && expire) |=> (cnt_q == '0));

endmodule

// File: rtl/arb_park_select.sv
// Module: arb_park_select
// Chooses who holds the slave when no request is pending, based on the
// park policy. An out-of-range fixed master number means no parking.
// Assumes: cur_id / cur_vld describe the owner in the current cycle.
module arb_park_select
    import arb_pkg::*;
#(
    parameter int unsigned N    = 10,
    parameter int unsigned ID_W = $clog2(N)
) (
    input  park_mode_e      mode,
    input  logic [ID_W-1:0] fixed_id,
    input  logic [ID_W-1:0] cur_id,
    input  logic            cur_vld,
    output logic            park_vld,
    output logic [ID_W-1:0] park_id
);

    logic fixed_ok;

    // Purpose: range-check the programmed fixed master number.
    always_comb fixed_ok = ({1'b0, fixed_id} < (ID_W + 1)'(N));

    // Purpose: map the policy to a parked owner.
    always_comb begin
        park_vld = 1'b0;
        park_id  = '0;
        unique case (mode)
            PARK_LAST: begin
                park_vld = cur_vld;
                park_id  = cur_id;
            end
            PARK_FIXED: begin
                park_vld = fixed_ok;
                park_id  = fixed_ok ? fixed_id : '0;
            end
            default: begin
                park_vld = 1'b0;
                park_id  = '0;
            end
        endcase
    end

endmodule

// File: rtl/matrix_slave_arbiter.sv
// Module: matrix_slave_arbiter
// Arbiter for one slave port of a bus matrix. It holds a registered owner.
// Each cycle it decides whether the owner keeps the port. A hand-over
// happens on a burst end, a slot-limit break, or an idle owner. The new
// owner comes from the rotating picker, or from the park policy when
// nothing is requested.
// Assumes: masters hold req through their burst and pulse last on the
// final beat; all inputs are synchronous to clk.
module matrix_slave_arbiter
    import arb_pkg::*;
#(
    parameter int unsigned NUM_MASTERS = 10,
    parameter int unsigned SLOT_W      = 8,
    parameter int unsigned ID_W        = $clog2(NUM_MASTERS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req_i,
    input  logic [NUM_MASTERS-1:0] lock_i,
    input  logic [NUM_MASTERS-1:0] last_i,
    input  logic [1:0]             park_mode_i,
    input  logic [ID_W-1:0]        park_id_i,
    input  logic [SLOT_W-1:0]      slot_limit_i,
    output logic [NUM_MASTERS-1:0] grant_o,
    output logic                   grant_valid_o
);

    localparam logic [ID_W-1:0] TOP_ID = ID_W'(NUM_MASTERS - 1);

    logic [ID_W-1:0]        owner_q;
    logic                   owner_vld_q;
    logic [ID_W-1:0]        ptr_q;
    logic [NUM_MASTERS-1:0] grant_hot;
    logic                   active;
    logic                   owner_lock;
    logic                   owner_last;
    logic                   end_last;
    logic                   expire;
    logic                   rearb;
    logic [NUM_MASTERS-1:0] arb_req;
    logic                   pick_any;
    logic [ID_W-1:0]        pick_id;
    logic                   park_vld;
    logic [ID_W-1:0]        park_id;
    park_mode_e             mode;

    // One grant bit per master, decoded from the registered owner.
    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_grant
        assign grant_hot[g] = owner_vld_q && (owner_q == ID_W'(g));
    end

    // Purpose: derive this cycle's beat, burst-end and hand-over conditions.
    always_comb begin
        mode       = park_mode_e'(park_mode_i);
        active     = |(grant_hot & req_i);
        owner_lock = |(grant_hot & lock_i);
        owner_last = |(grant_hot & last_i);
        end_last   = active && owner_last;
        rearb      = !active || end_last || expire;
        arb_req    = end_last ? (req_i & ~grant_hot) : req_i;
    end

    arb_rr_pick #(
        .N    (NUM_MASTERS),
        .ID_W (ID_W)
    ) u_pick (
        .req  (arb_req),
        .ptr  (ptr_q),
        .any  (pick_any),
        .pick (pick_id)
    );

    arb_slot_timer #(
        .CW (SLOT_W)
    ) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat     (active),
        .end_last (end_last),
        .lock_in  (owner_lock),
        .limit    (slot_limit_i),
        .expire   (expire)
    );

    arb_park_select #(
        .N    (NUM_MASTERS),
        .ID_W (ID_W)
    ) u_park (
        .mode     (mode),
        .fixed_id (park_id_i),
        .cur_id   (owner_q),
        .cur_vld  (owner_vld_q),
        .park_vld (park_vld),
        .park_id  (park_id)
    );

    // Purpose: register the owner and the rotating pointer at each hand-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q     <= '0;
            owner_vld_q <= 1'b0;
            ptr_q       <= '0;
        end else if (rearb) begin
            if (pick_any) begin
                owner_q     <= pick_id;
                owner_vld_q <= 1'b1;
                ptr_q       <= (pick_id == TOP_ID) ? '0 : pick_id + ID_W'(1);
            end else begin
                owner_q     <= park_id;
                owner_vld_q <= park_vld;
            end
        end
    end

    assign grant_o       = grant_hot;
    assign grant_valid_o = active;

    // R2: a valid beat always has exactly one granted master
    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> $onehot(grant_o));

    // R5: no parking leaves the port empty after an idle cycle
    assert_park_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((park_mode_i == 2'd0 || park_mode_i == 2'd3) && req_i == '0)
        |=> (grant_o == '0));

    // R6: last-owner parking keeps the grant unchanged while idle
    assert_park_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (park_mode_i == 2'd1 && req_i == '0) |=> $stable(grant_o));

    // R7: fixed parking lands on the programmed master while idle
    assert_park_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (park_mode_i == 2'd2 && req_i == '0 && {1'b0, park_id_i} < (ID_W + 1)'(NUM_MASTERS))
        |=> (grant_o == (NUM_MASTERS'(1) << $past(park_id_i))));

    // R10: with no slot limit a running burst keeps its grant until it ends
    assert_no_limit_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_limit_i == '0 && grant_valid_o && !owner_last) |=> $stable(grant_o));

    // R11: a locked burst is never broken by the slot limit
    assert_lock_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && owner_lock && !owner_last) |=> $stable(grant_o));

endmodule

// File: tb/matrix_slave_arbiter_bench.sv
module matrix_slave_arbiter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] lock = '0;
    logic [N-1:0] last = '0;
    logic [1:0]   mode = 2'd0;
    logic [3:0]   pid = 4'd0;
    logic [7:0]   limit = 8'd0;
    logic [N-1:0] grant;
    logic         gv;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    matrix_slave_arbiter u_matrix_slave_arbiter (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req),
        .lock_i        (lock),
        .last_i        (last),
        .park_mode_i   (mode),
        .park_id_i     (pid),
        .slot_limit_i  (limit),
        .grant_o       (grant),
        .grant_valid_o (gv)
    );

    function automatic logic [N-1:0] b(input int i);
        return N'(1) << i;
    endfunction

    // Drive one cycle's inputs at the falling edge and let outputs settle.
    task automatic cyc(input logic [N-1:0] r, input logic [N-1:0] l, input logic [N-1:0] e);
        @(negedge clk);
        req  = r;
        lock = l;
        last = e;
        #1;
    endtask

    task automatic chk(input string tag, input logic [N-1:0] eg, input logic egv);
        checks++;
        if (grant !== eg || gv !== egv) begin
            errors++;
            $display("FAIL %s: grant=%h gv=%b expected grant=%h gv=%b", tag, grant, gv, eg, egv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req = '0; lock = '0; last = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1 and R5: reset state, then single-beat burst with no parking
    task automatic t_none();
        mode = 2'd0; limit = 8'd0;
        @(negedge clk); rst_n = 1'b0; #1;
        chk("R1 reset in progress", '0, 1'b0);
        do_reset();
        #1 chk("R1 after reset", '0, 1'b0);
        cyc(b(3), 0, b(3)); chk("R3 grant not yet visible", '0, 1'b0);
        cyc(b(3), 0, b(3)); chk("R2 beat of master 3", b(3), 1'b1);
        cyc(0, 0, 0);       chk("R5 released after end", '0, 1'b0);
        mode = 2'd3;
        cyc(b(3), 0, b(3)); chk("R5 code3 idle", '0, 1'b0);
        cyc(b(3), 0, b(3)); chk("R2 code3 beat", b(3), 1'b1);
        cyc(0, 0, 0);       chk("R5 code3 released", '0, 1'b0);
    endtask

    // R3 and R4: rotating order across three requesters and wrap 9 -> 0
    task automatic t_rr();
        logic [N-1:0] r;
        mode = 2'd0; limit = 8'd0;
        do_reset();
        r = b(1) | b(4) | b(7);
        cyc(r, 0, r); chk("R3 rr idle", '0, 1'b0);
        cyc(r, 0, r); chk("R3 rr first 1", b(1), 1'b1);
        cyc(r, 0, r); chk("R4 rr next 4", b(4), 1'b1);
        cyc(r, 0, r); chk("R4 rr next 7", b(7), 1'b1);
        cyc(r, 0, r); chk("R3 rr wrap to 1", b(1), 1'b1);
        do_reset();
        r = b(0) | b(9);
        cyc(r, 0, r); chk("R3 wrap idle", '0, 1'b0);
        cyc(r, 0, r); chk("R3 wrap first 0", b(0), 1'b1);
        cyc(r, 0, r); chk("R3 wrap next 9", b(9), 1'b1);
        cyc(r, 0, r); chk("R3 wrap back to 0", b(0), 1'b1);
    endtask

    // R6 and R8: last-owner parking and zero-latency reuse
    task automatic t_last();
        mode = 2'd1; limit = 8'd0;
        do_reset();
        cyc(b(5), 0, b(5)); chk("R6 idle after reset", '0, 1'b0);
        cyc(b(5), 0, b(5)); chk("R6 beat of 5", b(5), 1'b1);
        cyc(0, 0, 0);       chk("R6 parked on 5", b(5), 1'b0);
        cyc(0, 0, 0);       chk("R6 still parked on 5", b(5), 1'b0);
        cyc(b(5), 0, b(5)); chk("R8 parked master beats at once", b(5), 1'b1);
        cyc(b(2), 0, b(2)); chk("R6 other master waits", b(5), 1'b0);
        cyc(b(2), 0, b(2)); chk("R6 master 2 beat", b(2), 1'b1);
        cyc(0, 0, 0);       chk("R6 parked on 2", b(2), 1'b0);
    endtask

    // R7 and R8: fixed parking, zero latency, out-of-range number
    task automatic t_fixed();
        mode = 2'd2; pid = 4'd6; limit = 8'd0;
        do_reset();
        cyc(b(1), 0, b(1)); chk("R7 parked on 6 after reset", b(6), 1'b0);
        cyc(b(1), 0, b(1)); chk("R7 master 1 beat", b(1), 1'b1);
        cyc(0, 0, 0);       chk("R7 back on 6", b(6), 1'b0);
        cyc(b(6), 0, b(6)); chk("R8 fixed master beats at once", b(6), 1'b1);
        pid = 4'd12;
        cyc(0, 0, 0);       chk("R7 invalid number no park", '0, 1'b0);
        pid = 4'd6;
    endtask

    // R9: slot limit 3 alternates two long bursts
    task automatic t_slot();
        logic [N-1:0] r;
        mode = 2'd0; limit = 8'd3;
        do_reset();
        r = b(2) | b(8);
        cyc(r, 0, 0); chk("R9 idle", '0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            cyc(r, 0, 0); chk("R9 master 2 slot", b(2), 1'b1);
        end
        for (int i = 0; i < 3; i++) begin
            cyc(r, 0, 0); chk("R9 master 8 slot", b(8), 1'b1);
        end
        cyc(r, 0, 0); chk("R9 back to master 2", b(2), 1'b1);
        limit = 8'd0;
    endtask

    // R10: limit zero lets a burst run until its end flag
    task automatic t_nolimit();
        logic [N-1:0] r;
        mode = 2'd0; limit = 8'd0;
        do_reset();
        r = b(2) | b(8);
        cyc(r, 0, 0); chk("R10 idle", '0, 1'b0);
        for (int i = 0; i < 20; i++) begin
            cyc(r, 0, 0); chk("R10 master 2 holds", b(2), 1'b1);
        end
        cyc(r, 0, b(2)); chk("R10 final beat of 2", b(2), 1'b1);
        cyc(r, 0, 0);    chk("R10 handover to 8", b(8), 1'b1);
    endtask

    // R11: lock shields the burst, release breaks it at once
    task automatic t_lock();
        logic [N-1:0] r;
        mode = 2'd0; limit = 8'd2;
        do_reset();
        r = b(2) | b(8);
        cyc(r, b(2), 0); chk("R11 idle", '0, 1'b0);
        for (int i = 0; i < 5; i++) begin
            cyc(r, b(2), 0); chk("R11 locked master 2", b(2), 1'b1);
        end
        cyc(r, 0, 0); chk("R11 unlock beat of 2", b(2), 1'b1);
        cyc(r, 0, 0); chk("R11 broken to 8", b(8), 1'b1);
        limit = 8'd0;
    endtask

    // R12: end flag and slot expiry on the same beat
    task automatic t_collide();
        mode = 2'd0; limit = 8'd2;
        do_reset();
        cyc(b(3), 0, 0);    chk("R12 idle", '0, 1'b0);
        cyc(b(3), 0, 0);    chk("R12 first beat", b(3), 1'b1);
        cyc(b(3), 0, b(3)); chk("R12 beat with end and expiry", b(3), 1'b1);
        cyc(b(3), 0, 0);    chk("R12 owner not regranted", '0, 1'b0);
        cyc(b(3), 0, 0);    chk("R12 new burst granted", b(3), 1'b1);
        limit = 8'd0;
    endtask

    initial begin
        t_none();
        t_rr();
        t_last();
        t_fixed();
        t_slot();
        t_nolimit();
        t_lock();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule